// File: doc/BRIEF.md
# Scratchpad Copy Authorization and Commit Unit

This unit sits between the command layer of a small nonvolatile memory and its storage array. When the master asks to move the 8-byte scratchpad into memory, the unit checks a set of conditions. The target must be aligned and in range. The scratchpad must be completely and validly filled. The master must repeat the address and status bytes exactly. The page protection codes and the global copy-protection code must allow the write. If the copy is allowed, the unit writes the eight bytes to the array one per cycle and then reports completion. On completion it also sets the transferred flag of the status byte.

The address space consists of `MAIN_ROWS` main-memory rows of 8 bytes. Main memory is split into pages of `PAGE_ROWS` rows. After main memory come a control row and a user row. The control row holds one protection byte per page, then the copy-protection byte. The unit receives these control bytes as a vector. A protection byte holding one of the two locking codes also guards itself: a copy into the control row writes back that byte's current value.

Top module: `cpy_commit`

## Requirements
- R1: An accepted request writes 8 bytes on 8 consecutive cycles. The writes start the cycle after the request. Addresses run from the target row's byte 0 up to byte 7. Byte k of the write comes from `sp_data[8k+7:8k]`.
- R2: A request whose target address has bits [2:0] not equal to 000 is rejected.
- R3: A request is rejected when the status PF bit is 1 or the ending offset E[2:0] is not 7.
- R4: A request is rejected unless `auth_ta` equals `ta` and `auth_es` equals the status byte. The status byte is built with AA in bit 7, PF in bit 5, E[2:0] in bits 2..0, and zeros elsewhere.
- R5: A main-memory page whose protection byte is 0x55 still accepts a copy while the copy-protection byte holds no locking code.
- R6: When the copy-protection byte is 0x55 or 0xAA, a copy into a page protected with 0x55 is rejected. Pages holding 0xAA or any other code are not blocked by this rule.
- R7: When the copy-protection byte is 0x55 or 0xAA, copies into the control row (row `MAIN_ROWS`) and the user row (row `MAIN_ROWS+1`) are rejected.
- R8: A request targeting a row above the user row is rejected.
- R9: In a copy to the control row, protection byte p (control-row byte p, p < pages) that currently holds 0x55 or 0xAA is written back with its current value. Every other byte takes the scratchpad value.
- R10: A rejected request raises `reject` for exactly one cycle, the cycle after the request. It produces no memory write, no `done` and no `aa_set`.
- R11: `done` and `aa_set` pulse together for one cycle, the cycle after the last write.
- R12: A request arriving while `busy` is high is ignored. It gives no reject and no change to the ongoing writes.
- R13: After reset, `busy`, `wr_en`, `reject`, `done` and `aa_set` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Copy request, sampled when idle |
| ta | input | ADDR_W | Target address register |
| es_e | input | 3 | Scratchpad ending offset |
| es_pf | input | 1 | Scratchpad invalid flag |
| es_aa | input | 1 | Transferred flag as currently held |
| auth_ta | input | ADDR_W | Address repeated by the master |
| auth_es | input | 8 | Status byte repeated by the master |
| prot_bytes | input | (PAGES+1)*8 | Page protection bytes, copy-protection byte on top |
| sp_data | input | 64 | Scratchpad contents, byte 0 lowest |
| busy | output | 1 | Commit in progress |
| wr_en | output | 1 | Memory byte write strobe |
| wr_addr | output | ADDR_W | Memory byte address |
| wr_data | output | 8 | Memory byte data |
| reject | output | 1 | One-cycle refusal pulse |
| done | output | 1 | One-cycle completion pulse |
| aa_set | output | 1 | Sets the transferred flag |

## Verification
The bench builds the unit with its defaults: a 16-bit address, 16 main rows and 4 rows per page. This gives four pages, with the control row at 0x80 and the user row at 0x88. At that size a single short run covers every protection page, the last main row, both special rows and the first out-of-range row. It also puts a control byte of each kind into the register-row merge, so the self-locking write-back is seen next to bytes that pass through.

// File: rtl/cpy_pkg.sv
package cpy_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_DONE  = 2'd2
    } cpy_state_e;

    localparam logic [7:0] CODE_WPROT = 8'h55;
    localparam logic [7:0] CODE_OTP   = 8'hAA;

    function automatic logic is_lock_code(input logic [7:0] b);
        return (b == CODE_WPROT) || (b == CODE_OTP);
    endfunction

    function automatic logic [7:0] make_status(input logic aa, input logic pf,
                                               input logic [2:0] e);
        return {aa, 1'b0, pf, 2'b00, e};
    endfunction
endpackage

// File: rtl/cpy_auth.sv
module cpy_auth
    import cpy_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MAIN_ROWS = 16,
    parameter int PAGE_ROWS = 4,
    localparam int PAGES    = MAIN_ROWS / PAGE_ROWS,
    localparam int ROW_W    = ADDR_W - 3
) (
    input  logic [ADDR_W-1:0]      ta,
    input  logic [2:0]             es_e,
    input  logic                   es_pf,
    input  logic                   es_aa,
    input  logic [ADDR_W-1:0]      auth_ta,
    input  logic [7:0]             auth_es,
    input  logic [(PAGES+1)*8-1:0] prot_bytes,
    output logic                   allow,
    output logic                   to_ctrl_row
);
    logic [ROW_W-1:0] row;
    logic [7:0]       page_code;
    logic [7:0]       copy_code;
    logic             in_main, in_ctrl, in_user;
    logic             aligned, filled, echoed, blocked;

    assign row       = ta[ADDR_W-1:3];
    assign copy_code = prot_bytes[PAGES*8 +: 8];
    assign in_main   = row < ROW_W'(MAIN_ROWS);
    assign in_ctrl   = row == ROW_W'(MAIN_ROWS);
    assign in_user   = row == ROW_W'(MAIN_ROWS + 1);

    always_comb begin
        page_code = '0;
        for (int p = 0; p < PAGES; p++) begin
            if (row >= ROW_W'(p * PAGE_ROWS) && row < ROW_W'((p + 1) * PAGE_ROWS))
                page_code = prot_bytes[p*8 +: 8];
        end
    end

    assign aligned = ta[2:0] == 3'b000;
    assign filled  = !es_pf && (es_e == 3'd7);
    assign echoed  = (auth_ta == ta) && (auth_es == make_status(es_aa, es_pf, es_e));
    assign blocked = is_lock_code(copy_code) &&
                     (in_ctrl || in_user || (in_main && page_code == CODE_WPROT));

    assign allow       = aligned && filled && echoed && (in_main || in_ctrl || in_user) && !blocked;
    assign to_ctrl_row = in_ctrl;
endmodule

// File: rtl/cpy_merge.sv
module cpy_merge
    import cpy_pkg::*;
#(
    parameter int PAGES = 4
) (
    input  logic [63:0]          sp_data,
    input  logic [PAGES*8-1:0]   page_codes,
    input  logic                 to_ctrl_row,
    output logic [63:0]          commit_data
);
    for (genvar b = 0; b < 8; b++) begin : g_byte
        if (b < PAGES) begin : g_guarded
            logic keep;
            assign keep = to_ctrl_row && is_lock_code(page_codes[b*8 +: 8]);
            assign commit_data[b*8 +: 8] = keep ? page_codes[b*8 +: 8] : sp_data[b*8 +: 8];
        end else begin : g_plain
            assign commit_data[b*8 +: 8] = sp_data[b*8 +: 8];
        end
    end
endmodule

// File: rtl/cpy_commit.sv
module cpy_commit
    import cpy_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MAIN_ROWS = 16,
    parameter int PAGE_ROWS = 4,
    localparam int PAGES    = MAIN_ROWS / PAGE_ROWS,
    localparam int ROW_W    = ADDR_W - 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req,
    input  logic [ADDR_W-1:0]      ta,
    input  logic [2:0]             es_e,
    input  logic                   es_pf,
    input  logic                   es_aa,
    input  logic [ADDR_W-1:0]      auth_ta,
    input  logic [7:0]             auth_es,
    input  logic [(PAGES+1)*8-1:0] prot_bytes,
    input  logic [63:0]            sp_data,
    output logic                   busy,
    output logic                   wr_en,
    output logic [ADDR_W-1:0]      wr_addr,
    output logic [7:0]             wr_data,
    output logic                   reject,
    output logic                   done,
    output logic                   aa_set
);
    typedef struct packed {
        cpy_state_e       st;
        logic [2:0]       idx;
        logic [ROW_W-1:0] row;
        logic [63:0]      data;
        logic             rej;
    } regs_t;

    regs_t       r_d, r_q;
    logic        allow;
    logic        to_ctrl_row;
    logic [63:0] commit_data;

    cpy_auth #(
        .ADDR_W   (ADDR_W),
        .MAIN_ROWS(MAIN_ROWS),
        .PAGE_ROWS(PAGE_ROWS)
    ) u_auth (
        .ta         (ta),
        .es_e       (es_e),
        .es_pf      (es_pf),
        .es_aa      (es_aa),
        .auth_ta    (auth_ta),
        .auth_es    (auth_es),
        .prot_bytes (prot_bytes),
        .allow      (allow),
        .to_ctrl_row(to_ctrl_row)
    );

    cpy_merge #(
        .PAGES(PAGES)
    ) u_merge (
        .sp_data    (sp_data),
        .page_codes (prot_bytes[PAGES*8-1:0]),
        .to_ctrl_row(to_ctrl_row),
        .commit_data(commit_data)
    );

    always_comb begin
        r_d     = r_q;
        r_d.rej = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req) begin
                    if (allow) begin
                        r_d.st   = ST_WRITE;
                        r_d.idx  = 3'd0;
                        r_d.row  = ta[ADDR_W-1:3];
                        r_d.data = commit_data;
                    end else begin
                        r_d.rej = 1'b1;
                    end
                end
            end
            ST_WRITE: begin
                r_d.idx = r_q.idx + 3'd1;
                if (r_q.idx == 3'd7) r_d.st = ST_DONE;
            end
            ST_DONE:  r_d.st = ST_IDLE;
            default:  r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, idx: '0, row: '0, data: '0, rej: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = r_q.st != ST_IDLE;
    assign wr_en   = r_q.st == ST_WRITE;
    assign wr_addr = {r_q.row, r_q.idx};
    assign wr_data = r_q.data[{r_q.idx, 3'b000} +: 8];
    assign reject  = r_q.rej;
    assign done    = r_q.st == ST_DONE;
    assign aa_set  = done;
endmodule

// File: rtl/cpy_commit_chk.sv
module cpy_commit_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              busy,
    input logic [ADDR_W-1:0] ta,
    input logic              es_pf,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              reject,
    input logic              done,
    input logic              aa_set
);
    assert_misaligned_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy && ta[2:0] != 3'b000) |=> reject);

    assert_invalid_fill_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy && es_pf) |=> reject);

    assert_reject_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> (!wr_en && !done && !aa_set));

    assert_first_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> (wr_addr[2:0] == 3'd0));

    assert_ascending_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + ADDR_W'(1)));

    assert_done_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_en) && $past(wr_addr[2:0]) == 3'd7));

    assert_done_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> aa_set);

    assert_busy_ignores_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req) |=> !reject);
endmodule

bind cpy_commit cpy_commit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .busy   (busy),
    .ta     (ta),
    .es_pf  (es_pf),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .reject (reject),
    .done   (done),
    .aa_set (aa_set)
);

// File: tb/tb_cpy_commit.sv
module tb_cpy_commit;
    localparam int ADDR_W = 16;
    localparam int PAGES  = 4;
    localparam logic [63:0] SP = 64'hF7E6D5C4B3A29180;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   req = 1'b0;
    logic [ADDR_W-1:0]      ta = '0;
    logic [2:0]             es_e = '0;
    logic                   es_pf = 1'b0;
    logic                   es_aa = 1'b0;
    logic [ADDR_W-1:0]      auth_ta = '0;
    logic [7:0]             auth_es = '0;
    logic [(PAGES+1)*8-1:0] prot_bytes = '0;
    logic [63:0]            sp_data = SP;
    logic                   busy, wr_en, reject, done, aa_set;
    logic [ADDR_W-1:0]      wr_addr;
    logic [7:0]             wr_data;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    cpy_commit dut (
        .clk(clk), .rst_n(rst_n), .req(req), .ta(ta), .es_e(es_e), .es_pf(es_pf),
        .es_aa(es_aa), .auth_ta(auth_ta), .auth_es(auth_es), .prot_bytes(prot_bytes),
        .sp_data(sp_data), .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .reject(reject), .done(done), .aa_set(aa_set)
    );

    typedef struct packed {
        logic [15:0] ta;
        logic [2:0]  e;
        logic        pf;
        logic        bad_echo;
        logic [7:0]  page_code;
        logic [7:0]  copy_code;
        logic        ok;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 3'd7, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 4'd1},  // R1 plain copy
        '{16'h0003, 3'd7, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 4'd2},  // R2 misaligned
        '{16'h0008, 3'd7, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 4'd3},  // R3 PF set
        '{16'h0010, 3'd5, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 4'd3},  // R3 short fill
        '{16'h0018, 3'd7, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 4'd4},  // R4 bad echo
        '{16'h0020, 3'd7, 1'b0, 1'b0, 8'h55, 8'h00, 1'b1, 4'd5},  // R5 refresh
        '{16'h0020, 3'd7, 1'b0, 1'b0, 8'h55, 8'h55, 1'b0, 4'd6},  // R6 refresh blocked
        '{16'h0028, 3'd7, 1'b0, 1'b0, 8'h55, 8'hAA, 1'b0, 4'd6},  // R6 other code
        '{16'h0020, 3'd7, 1'b0, 1'b0, 8'hAA, 8'h55, 1'b1, 4'd6},  // R6 0xAA page ok
        '{16'h0040, 3'd7, 1'b0, 1'b0, 8'h00, 8'h55, 1'b1, 4'd6},  // R6 open page ok
        '{16'h0080, 3'd7, 1'b0, 1'b0, 8'h00, 8'hAA, 1'b0, 4'd7},  // R7 control row
        '{16'h0088, 3'd7, 1'b0, 1'b0, 8'h00, 8'h55, 1'b0, 4'd7},  // R7 user row
        '{16'h0088, 3'd7, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 4'd7},  // R7 user row open
        '{16'h0090, 3'd7, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 4'd8},  // R8 out of range
        '{16'h0078, 3'd7, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 4'd1}   // R1 last main row
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_copy(input logic [15:0] t, input logic [2:0] e, input logic pf,
                           input logic bad_echo, input logic [(PAGES+1)*8-1:0] pb,
                           input logic ok, input logic [63:0] exp_data,
                           input logic mid_req, input string tag);
        @(negedge clk);
        ta         = t;
        es_e       = e;
        es_pf      = pf;
        es_aa      = 1'b0;
        auth_ta    = t;
        auth_es    = {1'b0, 1'b0, pf, 2'b00, e} ^ (bad_echo ? 8'h08 : 8'h00);
        prot_bytes = pb;
        req        = 1'b1;
        @(negedge clk);
        req = 1'b0;
        if (!ok) begin
            // R10: pulse in the cycle after the request, no write
            chk({tag, " R10 reject"}, 64'(reject), 64'd1);
            chk({tag, " R10 no write"}, 64'(wr_en | done | aa_set), 64'd0);
            @(negedge clk);
            chk({tag, " R10 pulse width"}, 64'(reject), 64'd0);
        end else begin
            for (int k = 0; k < 8; k++) begin
                chk({tag, " R1 wr_en"}, 64'(wr_en), 64'd1);
                chk({tag, " R1 addr"}, 64'(wr_addr), 64'(t + 16'(k)));
                chk({tag, " R1 data"}, 64'(wr_data), 64'(exp_data[k*8 +: 8]));
                chk({tag, " R12 no reject"}, 64'(reject), 64'd0);
                if (mid_req && k == 2) begin
                    ta = 16'h0005;
                    req = 1'b1;
                end
                @(negedge clk);
                if (mid_req && k == 2) req = 1'b0;
            end
            // R11: completion and flag together after last byte
            chk({tag, " R11 done"}, 64'(done), 64'd1);
            chk({tag, " R11 aa_set"}, 64'(aa_set), 64'd1);
            chk({tag, " R11 no write"}, 64'(wr_en), 64'd0);
            @(negedge clk);
            chk({tag, " R11 done pulse"}, 64'(done | aa_set | busy), 64'd0);
            chk({tag, " R12 no reject"}, 64'(reject), 64'd0);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1;
        // R13: state held in reset
        chk("R13 reset", {59'd0, busy, wr_en, reject, done, aa_set}, 64'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 after reset", {59'd0, busy, wr_en, reject, done, aa_set}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            do_copy(VECS[i].ta, VECS[i].e, VECS[i].pf, VECS[i].bad_echo,
                    {VECS[i].copy_code, {PAGES{VECS[i].page_code}}},
                    VECS[i].ok, SP, 1'b0, $sformatf("vec%0d R%0d", i, VECS[i].tag));
        end

        // R9: locked control bytes keep their value, others take scratchpad
        do_copy(16'h0080, 3'd7, 1'b0, 1'b0, {8'h33, 8'h00, 8'h12, 8'hAA, 8'h55},
                1'b1, {SP[63:16], 8'hAA, 8'h55}, 1'b0, "R9 self lock");

        // R4: echoed status must include the AA bit in bit 7
        @(negedge clk);
        es_aa = 1'b1;
        ta = 16'h0030; auth_ta = 16'h0030; es_e = 3'd7; es_pf = 1'b0;
        prot_bytes = '0;
        auth_es = 8'h07;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk("R4 AA mismatch", 64'(reject), 64'd1);
        @(negedge clk);
        auth_es = 8'h87;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk("R4 AA match", {62'd0, reject, wr_en}, 64'd1);
        repeat (9) @(negedge clk);
        es_aa = 1'b0;

        // R12: request during commit is ignored
        do_copy(16'h0048, 3'd7, 1'b0, 1'b0, '0, 1'b1, SP, 1'b1, "R12 busy");

        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule